// File: doc/BRIEF.md
# Looping Switch-Setting Router for an Eight-Way Rearrangeable Network

This block is a sequential controller that works out every switch setting of a recursive rearrangeable permutation network. The network has, at each level, a column of two-by-two input switches, an upper and a lower half-size subnetwork, and a column of output switches. The user presents a destination table, which says for each input the output it must reach, and pulses `start`. The controller then walks the classic looping chain, alternating between the input side and the output side. It first sends output 0 back through the upper half to its source. The partner input of that source is sent through the lower half. The other output of the switch that the partner reaches is then sent through the upper half, and so on. When a chain closes, the walk restarts from a pair that is still unrouted.

The walk takes one step per clock, and each step fixes one input switch and at most one output switch. During each level the controller writes the two half-size destination tables into internal registers. It then repeats the walk on every subnetwork, down to the size-two switches. The output switch that carries output 0 of each subnetwork is always pass-through and has no control bit. When every bit is set, `done` goes high and the packed control vector is held until the next start. Checking that the table really is a permutation is left to the user.

Top module: `lsr_router`

## Requirements
- R1: While `rst_n` is low, and after it is released, `done` is 0 and `ctrl` is all zeros until a computation completes.
- R2: `start` is accepted when no computation is running. On acceptance the destination table is captured, so `dest` may change afterwards without effect, and `done` is 0 from the next cycle on. Entry i of the table is `dest[3i+2:3i]`.
- R3: `done` rises exactly N/2·log2(N) clock cycles after the edge that accepts `start`, which is 12 cycles for N = 8.
- R4: Applied to the network described in R5, `ctrl` moves the item on input i to output `dest[i]` for every permutation.
- R5: Layout. Stages s = 0..log2(N)−1 hold blocks of size m = N>>s, and block b at stage s feeds block 2b (upper) and block 2b+1 (lower) at stage s+1. Let OFF(s) = s·N − (2^s − 1). The input switch k of block b is bit OFF(s)+b·m/2+k. It takes the block inputs 2k and 2k+1. At 0 it sends 2k to upper input k and 2k+1 to lower input k; at 1 it crosses them. The output switch t ≥ 1 is bit OFF(s)+N/2+b·(m/2−1)+t−1. It takes upper output t and lower output t. At 0 they go to block outputs 2t and 2t+1; at 1 they are crossed. Output switch 0 is always 0 and is absent. The vector has N·log2(N)−N+1 = 17 bits, and the identity permutation gives all zeros.
- R6: Each block's walk starts from block output 0 through the upper half. When a chain closes, it restarts from the lowest-numbered unrouted input pair, with the even input sent through the upper half. For the pair-swap table (1,0,3,2,5,4,7,6) this gives `ctrl` = 0x00071; for the reversal table (7,6,...,0) it gives 0x1FD78.
- R7: While `done` is high and no `start` arrives, `done` stays high and `ctrl` is unchanged. A `start` pulse during a running computation is ignored, so the latency and the result are those of the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to route the table on `dest` |
| dest | input | N·log2(N) (24) | Destination table, entry i at bits [3i+2:3i] |
| done | output | 1 | High when `ctrl` holds a finished result |
| ctrl | output | N·log2(N)−N+1 (17) | Packed switch settings, layout as in R5 |

## Verification
Two events can fall in the same cycle: a fresh `start` and the closing of a chain. They meet either while the block is busy, where the `start` must lose, or in the cycle after `done` rises, where the `start` must begin a clean rerun. The bench drives a reversal table and pulses `start` again with the identity table partway through the run. It then judges the final vector against the reversal value 0x1FD78 and the latency against 12 cycles. Within a block, the step that closes a chain and the restart at the lowest unrouted pair happen in one cycle. The pair-swap and reversal vectors are chosen so that this restart happens at every stage, and they are compared bit for bit. About fifteen hundred random permutations are then pushed through a bench model of the network.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/lsr_src_find.sv
// Finds the local input index inside one block whose local destination equals want.
module lsr_src_find #(
    parameter  int LOG_N = 3,
    localparam int N     = 1 << LOG_N
) (
    input  logic [N-1:0][LOG_N-1:0] tbl,
    input  logic [LOG_N-1:0]        base,
    input  logic [LOG_N-1:0]        mask,
    input  logic [LOG_N-1:0]        want,
    output logic [LOG_N-1:0]        pos
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < N; i++) begin
            if (((LOG_N'(i) & ~mask) == base) && ((tbl[i] & mask) == want)) begin
                pos = LOG_N'(i) & mask;
            end
        end
    end
endmodule

// File: rtl/lsr_first_free.sv
// Lowest-numbered pair whose taken flag is clear.
module lsr_first_free #(
    parameter int P  = 4,
    parameter int PW = 2
) (
    input  logic [P-1:0]  taken,
    output logic [PW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int p = P - 1; p >= 0; p--) begin
            if (!taken[p]) begin
                idx   = PW'(p);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsr_router.sv
module lsr_router #(
    parameter  int LOG_N = 3,
    localparam int N     = 1 << LOG_N,
    localparam int W     = LOG_N * N - N + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N*LOG_N-1:0]   dest,
    output logic                 done,
    output logic [W-1:0]         ctrl
);
    localparam int HALF = N / 2;
    localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int CW   = $clog2(W);

    typedef struct packed {
        lsr_pkg::phase_e          ph;
        logic [LOG_N-1:0]         stg;
        logic [LOG_N-1:0]         blk;
        logic [N-1:0][LOG_N-1:0]  cur;
        logic [N-1:0][LOG_N-1:0]  nxt;
        logic [HALF-1:0]          routed;
        logic [LOG_N-1:0]         o;
        logic [W-1:0]             ctrl;
    } state_t;

    state_t r_q, r_d;

    logic [LOG_N-1:0] mask, base, pos_o, pos_n, dval, want_n;
    logic [HALF-1:0]  routed_nx, taken;
    logic [PW-1:0]    free_idx;
    logic             free_ok;

    always_comb begin
        mask   = LOG_N'((N >> r_q.stg) - 1);
        base   = LOG_N'(int'(r_q.blk) * (N >> r_q.stg));
        dval   = r_q.cur[base | (pos_o ^ LOG_N'(1))] & mask;
        want_n = dval ^ LOG_N'(1);
    end

    lsr_src_find #(.LOG_N(LOG_N)) i_find_cur (
        .tbl(r_q.cur), .base(base), .mask(mask), .want(r_q.o), .pos(pos_o)
    );

    lsr_src_find #(.LOG_N(LOG_N)) i_find_next (
        .tbl(r_q.cur), .base(base), .mask(mask), .want(want_n), .pos(pos_n)
    );

    always_comb begin
        routed_nx = r_q.routed;
        routed_nx[PW'(pos_o >> 1)] = 1'b1;
        for (int p = 0; p < HALF; p++) begin
            taken[p] = routed_nx[p] || (p >= ((N >> r_q.stg) / 2));
        end
    end

    lsr_first_free #(.P(HALF), .PW(PW)) i_free (
        .taken(taken), .idx(free_idx), .found(free_ok)
    );

    always_comb begin
        int m, h, off, k, mm;
        r_d = r_q;
        m   = N >> r_q.stg;
        h   = m / 2;
        off = int'(r_q.stg) * N - ((1 << r_q.stg) - 1);
        k   = int'(pos_o) >> 1;
        mm  = int'(dval) >> 1;
        case (r_q.ph)
            lsr_pkg::PH_RUN: begin
                // one chain step: input switch, two sub-table entries, output switch
                r_d.ctrl[CW'(off + int'(r_q.blk) * h + k)] = pos_o[0];
                r_d.nxt[LOG_N'(int'(base) + k)]     = r_q.o >> 1;
                r_d.nxt[LOG_N'(int'(base) + h + k)] = dval >> 1;
                if (mm != 0) begin
                    r_d.ctrl[CW'(off + HALF + int'(r_q.blk) * (h - 1) + mm - 1)] = ~dval[0];
                end
                r_d.routed = routed_nx;
                if (!routed_nx[PW'(pos_n >> 1)]) begin
                    r_d.o = want_n;
                end else if (free_ok) begin
                    r_d.o = r_q.cur[LOG_N'(int'(base) + 2 * int'(free_idx))] & mask;
                end else begin
                    r_d.routed = '0;
                    r_d.o      = '0;
                    if (int'(r_q.blk) == (1 << r_q.stg) - 1) begin
                        r_d.blk = '0;
                        r_d.cur = r_d.nxt;
                        if (int'(r_q.stg) == LOG_N - 1) begin
                            r_d.ph = lsr_pkg::PH_DONE;
                        end else begin
                            r_d.stg = r_q.stg + LOG_N'(1);
                        end
                    end else begin
                        r_d.blk = r_q.blk + LOG_N'(1);
                    end
                end
            end
            default: begin
                if (start) begin
                    r_d.ph     = lsr_pkg::PH_RUN;
                    r_d.stg    = '0;
                    r_d.blk    = '0;
                    r_d.routed = '0;
                    r_d.o      = '0;
                    r_d.ctrl   = '0;
                    for (int i = 0; i < N; i++) begin
                        r_d.cur[i] = dest[i*LOG_N +: LOG_N];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done = (r_q.ph == lsr_pkg::PH_DONE);
    assign ctrl = r_q.ctrl;
endmodule

// File: rtl/lsr_router_chk.sv
module lsr_router_chk #(
    parameter  int LOG_N = 3,
    localparam int N     = 1 << LOG_N,
    localparam int W     = LOG_N * N - N + 1,
    localparam int LAT   = (N / 2) * LOG_N
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [W-1:0] ctrl
);
    logic busy;
    int   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= 0;
        end else if (start && (!busy || done)) begin
            busy <= 1'b1;
            cnt  <= 0;
        end else if (busy && done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1;
        end
    end

    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    a_r7_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> $stable(ctrl));

    a_r2_done_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cnt == LAT));
endmodule

bind lsr_router lsr_router_chk #(.LOG_N(LOG_N)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .ctrl(ctrl)
);

// File: tb/test_lsr_router.sv
module test_lsr_router;
    localparam int LG = 3;
    localparam int N  = 8;
    localparam int W  = 17;
    localparam int NV = 3;
    // table vectors: destination table, expected control vector
    localparam logic [23:0]  VDEST [NV] = '{24'hFAC688, 24'hDE54C1, 24'h053977};
    localparam logic [W-1:0] VCTRL [NV] = '{17'h00000, 17'h00071, 17'h1FD78};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [23:0]    dest = '0;
    logic           done;
    logic [W-1:0]   ctrl;
    int             checks = 0;
    int             errs = 0;
    bit             over = 1'b0;

    always #4 clk = ~clk;

    lsr_router #(.LOG_N(LG)) i_lsr_router (
        .clk(clk), .rst_n(rst_n), .start(start), .dest(dest), .done(done), .ctrl(ctrl)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bench model of the network of R5; returns 1 when every input lands on its destination
    function automatic bit net_ok(input logic [W-1:0] c, input logic [23:0] dst);
        int a[8];
        int t[8];
        int m, h, off, base, u, l;
        logic [W-1:0] sh;
        bit ok;
        for (int i = 0; i < N; i++) a[i] = i;
        for (int s = 0; s < LG - 1; s++) begin
            m = N >> s; h = m / 2; off = s * N - ((1 << s) - 1);
            for (int b = 0; b < (1 << s); b++) begin
                base = b * m;
                for (int k = 0; k < h; k++) begin
                    sh = c >> (off + b * h + k);
                    u = a[base + 2*k]; l = a[base + 2*k + 1];
                    t[base + k]     = sh[0] ? l : u;
                    t[base + h + k] = sh[0] ? u : l;
                end
            end
            a = t;
        end
        off = (LG - 1) * N - ((1 << (LG - 1)) - 1);
        for (int b = 0; b < N / 2; b++) begin
            sh = c >> (off + b);
            if (sh[0]) begin
                u = a[2*b]; a[2*b] = a[2*b + 1]; a[2*b + 1] = u;
            end
        end
        for (int s = LG - 2; s >= 0; s--) begin
            m = N >> s; h = m / 2; off = s * N - ((1 << s) - 1);
            for (int b = 0; b < (1 << s); b++) begin
                base = b * m;
                for (int q = 0; q < h; q++) begin
                    sh = (q == 0) ? '0 : (c >> (off + N / 2 + b * (h - 1) + q - 1));
                    u = a[base + q]; l = a[base + h + q];
                    t[base + 2*q]     = sh[0] ? l : u;
                    t[base + 2*q + 1] = sh[0] ? u : l;
                end
            end
            a = t;
        end
        ok = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (a[int'(dst[3*i +: 3])] != i) ok = 1'b0;
        end
        return ok;
    endfunction

    // pulse start with dst; mid_at > 0 injects a second start with alt after that many cycles
    task automatic run(input logic [23:0] dst, input int mid_at, input logic [23:0] alt, output int lat);
        @(negedge clk);
        dest = dst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R2 done low after start", done, 0);
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (lat == 2) dest = ~dst;
            if (mid_at > 0 && lat == mid_at) begin
                dest = alt; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        int lat;
        int p[8];
        logic [23:0] dv;
        logic [W-1:0] held;
        #3;
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(ctrl == '0, "R1 ctrl in reset", ctrl, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && ctrl == '0, "R1 idle after reset", {done, ctrl}, 0);

        for (int v = 0; v < NV; v++) begin
            run(VDEST[v], 0, '0, lat);
            check(lat == 12, "R3 latency", lat, 12);
            check(ctrl == VCTRL[v], (v == 0) ? "R5 identity vector" : "R6 exact vector", ctrl, VCTRL[v]);
            check(net_ok(ctrl, VDEST[v]), "R4 table vector routes", ctrl, VCTRL[v]);
        end

        held = ctrl;
        repeat (10) @(negedge clk);
        check(done == 1'b1, "R7 done holds", done, 1);
        check(ctrl == held, "R7 ctrl holds", ctrl, held);

        run(24'h053977, 5, 24'hFAC688, lat);
        check(lat == 12, "R7 start during run ignored latency", lat, 12);
        check(ctrl == 17'h1FD78, "R7 start during run ignored result", ctrl, 17'h1FD78);

        for (int r = 0; r < 1500; r++) begin
            for (int i = 0; i < N; i++) p[i] = i;
            for (int i = N - 1; i > 0; i--) begin
                int j, tmp;
                j = int'($urandom_range(i, 0));
                tmp = p[i]; p[i] = p[j]; p[j] = tmp;
            end
            for (int i = 0; i < N; i++) dv[3*i +: 3] = 3'(p[i]);
            run(dv, 0, '0, lat);
            check(lat == 12, "R3 latency random", lat, 12);
            check(net_ok(ctrl, dv), "R4 random permutation routes", ctrl, dv);
        end

        @(negedge clk);
        dest = 24'h053977; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(done == 1'b0 && ctrl == '0, "R1 reset mid-run", {done, ctrl}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run(24'hDE54C1, 0, '0, lat);
        check(lat == 12 && ctrl == 17'h00071, "R6 rerun after reset", ctrl, 17'h00071);

        over = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        #1600000;
        if (!over) begin
            over = 1'b1;
            checks++;
            errs++;
            $display("FAIL R3 watchdog expired: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end
endmodule